// File: doc/BRIEF.md
# Latched bidirectional bus transceiver

This block sits between two parallel buses, called A and B, and moves data in either direction through a storage stage for each direction. The datapath is cut into byte-wide sections (two sections of eight bits by default). Each section has its own control set, so the block can serve as several independent byte transceivers or as one wide transceiver when the controls are tied together. For each direction, each section has three active-low controls: a direction enable, a capture control and a drive control.

A direction's latch is open, with its output following its input bus in the same cycle, only while both its direction enable and its capture control are low. Raising either one closes the latch. The latch then keeps the value it sampled at the last clock edge on which it was open. The opposite bus is driven from the latch only while the direction enable and the drive control are both low, and only while the power-good input is high. Tri-state pins are modelled as separate input, output and per-bit drive-enable vectors. A per-bit valid flag on each input bus models bus-hold: a bit that is not being driven reads as the last value it held while it was driven.

Each section raises a contention flag when both of its directions are open and driving at once. In that case the two buses would form a combinational loop through the block.

Top module: `xcvr_latched_bidir`

## Requirements
- R1: After reset, every stored latch value and every held bus value is zero. With the direction enable low, the capture control high and the drive control low, the driven port shows 0.
- R2: While the A-to-B direction enable and capture control of a section are both low, that section's B data output equals the effective A input in the same cycle.
- R3: When the A-to-B capture control goes high while the direction enable stays low, B shows the A value that was present at the last clock edge while the latch was open, and A changes no longer reach B.
- R4: A rising A-to-B direction enable also closes the latch. An A value presented while the direction enable is high is never stored.
- R5: Each bit of the B drive-enable is 1 only while that section's A-to-B direction enable and drive control are both low. Otherwise it is 0.
- R6: With the direction enable low, the capture control high and the drive control low, the B port keeps driving the stored value.
- R7: The B-to-A path follows R2 to R6 with its own controls, storing B and driving A.
- R8: Section k owns data bits [8k+7:8k] and the control bits at index k. The controls of one section have no effect on the bits of any other section.
- R9: For each input bit whose valid flag is 0, the effective input is the value that bit carried at the last clock edge at which its valid flag was 1, or 0 if there was none since reset.
- R10: While power_good_i is 0, all A and B drive-enable bits are 0, whatever the controls are.
- R11: A section's contention flag is 1 exactly when both of its latches are open and both of its directions are driving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| power_good_i | input | 1 | 1 when the supply is stable; 0 forces all drive-enables off |
| ab_en_ni | input | N_SEC | A-to-B direction enable per section, active low |
| ab_cap_ni | input | N_SEC | A-to-B capture control per section, active low |
| ab_drv_ni | input | N_SEC | A-to-B drive control per section, active low |
| ba_en_ni | input | N_SEC | B-to-A direction enable per section, active low |
| ba_cap_ni | input | N_SEC | B-to-A capture control per section, active low |
| ba_drv_ni | input | N_SEC | B-to-A drive control per section, active low |
| a_i | input | W | Value seen on the A bus |
| a_valid_i | input | W | Per-bit flag: A bit is externally driven |
| a_o | output | W | Value the block puts on the A bus |
| a_oe_o | output | W | Per-bit drive-enable for the A bus |
| b_i | input | W | Value seen on the B bus |
| b_valid_i | input | W | Per-bit flag: B bit is externally driven |
| b_o | output | W | Value the block puts on the B bus |
| b_oe_o | output | W | Per-bit drive-enable for the B bus |
| contention_o | output | N_SEC | Per-section flag: both directions open and driving |

## Verification
A wrong stored latch value stays hidden while the latch is open. It appears on the opposite bus in the first cycle after the latch closes, provided the drive control is low, and it persists until the latch reopens. A wrong bus-hold value appears in the same cycle that a valid flag drops, but only through an open latch. The bench therefore opens the latch when it checks undriven bits. Wrong gating of the enables appears at once on the drive-enable vectors and the contention flags. Those outputs are compared against the expected values in every cycle.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned SEC_W_DEF = 8;
  localparam int unsigned N_SEC_DEF = 2;

  typedef struct packed {
    logic en_n;
    logic cap_n;
    logic drv_n;
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_bus_hold.sv
module xcvr_bus_hold #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] valid_i,
  output logic [W-1:0] eff_o
);
  logic [W-1:0] held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '0;
    else         held_q <= eff_o;
  end

  assign eff_o = (data_i & valid_i) | (held_q & ~valid_i);

  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i == '0) && $past(valid_i == '0) |-> $stable(eff_o));
  // R9
  hold_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i == '1) && (valid_i == '0) |-> eff_o == $past(data_i));
endmodule

// File: rtl/xcvr_dir_latch.sv
module xcvr_dir_latch
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  dir_ctrl_t ctrl_i,
  input  logic      power_good_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic      open_o,
  output logic      drive_o
);
  logic [W-1:0] store_q;

  // gate is the NOR of enable and capture
  assign open_o  = ~(ctrl_i.en_n | ctrl_i.cap_n);
  assign drive_o = power_good_i & ~ctrl_i.en_n & ~ctrl_i.drv_n;
  assign q_o     = open_o ? d_i : store_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     store_q <= '0;
    else if (open_o) store_q <= d_i;
  end

  // R3
  closed_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_o && $past(!open_o) |-> $stable(q_o));
  // R4
  en_high_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.en_n |-> !open_o && !drive_o);
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      power_good_i,
  input  dir_ctrl_t ab_ctrl_i,
  input  dir_ctrl_t ba_ctrl_i,
  input  logic [W-1:0] a_eff_i,
  input  logic [W-1:0] b_eff_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o,
  output logic      contention_o
);
  logic ab_open, ab_drive, ba_open, ba_drive;

  xcvr_dir_latch #(.W(W)) i_ab (
    .clk_i, .rst_ni, .ctrl_i(ab_ctrl_i), .power_good_i,
    .d_i(a_eff_i), .q_o(b_o), .open_o(ab_open), .drive_o(ab_drive)
  );

  xcvr_dir_latch #(.W(W)) i_ba (
    .clk_i, .rst_ni, .ctrl_i(ba_ctrl_i), .power_good_i,
    .d_i(b_eff_i), .q_o(a_o), .open_o(ba_open), .drive_o(ba_drive)
  );

  assign b_oe_o       = {W{ab_drive}};
  assign a_oe_o       = {W{ba_drive}};
  assign contention_o = ab_open & ba_open & ab_drive & ba_drive;

  // R5
  b_drive_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ab_ctrl_i.en_n || ab_ctrl_i.drv_n) |-> b_oe_o == '0);
  // R7
  a_drive_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ba_ctrl_i.en_n || ba_ctrl_i.drv_n) |-> a_oe_o == '0);
  // R11
  contention_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    contention_o |-> (a_oe_o != '0) && (b_oe_o != '0));
endmodule

// File: rtl/xcvr_latched_bidir.sv
module xcvr_latched_bidir
  import xcvr_pkg::*;
#(
  parameter int unsigned SEC_W = SEC_W_DEF,
  parameter int unsigned N_SEC = N_SEC_DEF,
  localparam int unsigned W    = SEC_W * N_SEC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             power_good_i,
  input  logic [N_SEC-1:0] ab_en_ni,
  input  logic [N_SEC-1:0] ab_cap_ni,
  input  logic [N_SEC-1:0] ab_drv_ni,
  input  logic [N_SEC-1:0] ba_en_ni,
  input  logic [N_SEC-1:0] ba_cap_ni,
  input  logic [N_SEC-1:0] ba_drv_ni,
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     a_valid_i,
  output logic [W-1:0]     a_o,
  output logic [W-1:0]     a_oe_o,
  input  logic [W-1:0]     b_i,
  input  logic [W-1:0]     b_valid_i,
  output logic [W-1:0]     b_o,
  output logic [W-1:0]     b_oe_o,
  output logic [N_SEC-1:0] contention_o
);
  logic [W-1:0] a_eff, b_eff;

  xcvr_bus_hold #(.W(W)) i_hold_a (
    .clk_i, .rst_ni, .data_i(a_i), .valid_i(a_valid_i), .eff_o(a_eff)
  );
  xcvr_bus_hold #(.W(W)) i_hold_b (
    .clk_i, .rst_ni, .data_i(b_i), .valid_i(b_valid_i), .eff_o(b_eff)
  );

  for (genvar s = 0; s < N_SEC; s++) begin : g_sec
    dir_ctrl_t ab_ctrl, ba_ctrl;
    assign ab_ctrl = '{en_n: ab_en_ni[s], cap_n: ab_cap_ni[s], drv_n: ab_drv_ni[s]};
    assign ba_ctrl = '{en_n: ba_en_ni[s], cap_n: ba_cap_ni[s], drv_n: ba_drv_ni[s]};

    xcvr_section #(.W(SEC_W)) i_sec (
      .clk_i, .rst_ni, .power_good_i,
      .ab_ctrl_i   (ab_ctrl),
      .ba_ctrl_i   (ba_ctrl),
      .a_eff_i     (a_eff[s*SEC_W +: SEC_W]),
      .b_eff_i     (b_eff[s*SEC_W +: SEC_W]),
      .a_o         (a_o[s*SEC_W +: SEC_W]),
      .a_oe_o      (a_oe_o[s*SEC_W +: SEC_W]),
      .b_o         (b_o[s*SEC_W +: SEC_W]),
      .b_oe_o      (b_oe_o[s*SEC_W +: SEC_W]),
      .contention_o(contention_o[s])
    );
  end

  // R10
  power_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !power_good_i |-> (a_oe_o == '0) && (b_oe_o == '0) && (contention_o == '0));
endmodule

// File: tb/test_xcvr_latched_bidir.sv
module test_xcvr_latched_bidir;
  localparam int SW = 8;
  localparam int NS = 2;
  localparam int W  = SW * NS;

  logic clk = 1'b0, rst_ni = 1'b0, pwr = 1'b1;
  logic [NS-1:0] ab_en = '1, ab_cap = '1, ab_drv = '1;
  logic [NS-1:0] ba_en = '1, ba_cap = '1, ba_drv = '1;
  logic [W-1:0] a_in = '0, a_val = '1, b_in = '0, b_val = '1;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic [NS-1:0] cont;

  always #5 clk = ~clk;

  xcvr_latched_bidir i_xcvr_latched_bidir (
    .clk_i(clk), .rst_ni, .power_good_i(pwr),
    .ab_en_ni(ab_en), .ab_cap_ni(ab_cap), .ab_drv_ni(ab_drv),
    .ba_en_ni(ba_en), .ba_cap_ni(ba_cap), .ba_drv_ni(ba_drv),
    .a_i(a_in), .a_valid_i(a_val), .a_o(a_out), .a_oe_o(a_oe),
    .b_i(b_in), .b_valid_i(b_val), .b_o(b_out), .b_oe_o(b_oe),
    .contention_o(cont)
  );

  typedef struct {
    logic [W-1:0]  a, aoe, b, boe;
    logic [NS-1:0] c;
    string         tag;
  } exp_t;

  exp_t q[$];
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference state
  logic [SW-1:0] m_ab [NS], m_ba [NS];
  logic [W-1:0]  m_ha, m_hb;

  function automatic exp_t model(string tag);
    exp_t e;
    logic [W-1:0] ae, be;
    ae = (a_in & a_val) | (m_ha & ~a_val);
    be = (b_in & b_val) | (m_hb & ~b_val);
    e.tag = tag;
    for (int s = 0; s < NS; s++) begin
      bit oab, oba, dab, dba;
      oab = !ab_en[s] && !ab_cap[s];
      oba = !ba_en[s] && !ba_cap[s];
      dab = pwr && !ab_en[s] && !ab_drv[s];
      dba = pwr && !ba_en[s] && !ba_drv[s];
      e.b[s*SW +: SW]   = oab ? ae[s*SW +: SW] : m_ab[s];
      e.a[s*SW +: SW]   = oba ? be[s*SW +: SW] : m_ba[s];
      e.boe[s*SW +: SW] = {SW{dab}};
      e.aoe[s*SW +: SW] = {SW{dba}};
      e.c[s]            = oab && oba && dab && dba;
    end
    return e;
  endfunction

  task automatic model_clock();
    logic [W-1:0] ae, be;
    ae = (a_in & a_val) | (m_ha & ~a_val);
    be = (b_in & b_val) | (m_hb & ~b_val);
    for (int s = 0; s < NS; s++) begin
      if (!ab_en[s] && !ab_cap[s]) m_ab[s] = ae[s*SW +: SW];
      if (!ba_en[s] && !ba_cap[s]) m_ba[s] = be[s*SW +: SW];
    end
    m_ha = ae;
    m_hb = be;
  endtask

  task automatic step(string tag);
    q.push_back(model(tag));
    @(posedge clk);
    model_clock();
  endtask

  task automatic report(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      report(e.tag, "a_oe", a_oe, e.aoe);
      report(e.tag, "b_oe", b_oe, e.boe);
      report(e.tag, "a_o", a_out & e.aoe, e.a & e.aoe);
      report(e.tag, "b_o", b_out & e.boe, e.b & e.boe);
      report(e.tag, "contention", W'(cont), W'(e.c));
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int s = 0; s < NS; s++) begin m_ab[s] = '0; m_ba[s] = '0; end
    m_ha = '0; m_hb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;

    // R1: stored values are zero after reset
    @(negedge clk); ab_en = '0; ab_drv = '0; ba_en = '0; ba_drv = '0; step("R1");
    // R1: held value zero: open AB with A undriven
    @(negedge clk); ba_en = '1; ab_cap = '0; a_val = '0; a_in = 16'hffff; step("R1_hold");
    a_val = '1;

    // R2: transparent
    @(negedge clk); a_in = 16'h1234; step("R2");
    @(negedge clk); a_in = 16'habcd; step("R2");
    // R3: capture rises, A changes do not pass
    @(negedge clk); ab_cap = '1; a_in = 16'h5555; step("R3");
    @(negedge clk); a_in = 16'h9999; step("R3");
    // R4: enable rising closes latch and tristates
    @(negedge clk); ab_cap = '0; a_in = 16'h0f0f; step("R4");
    @(negedge clk); ab_en = '1; a_in = 16'hffff; step("R4");
    @(negedge clk); a_in = 16'h7777; step("R4");
    // R6: stored value driven
    @(negedge clk); ab_en = '0; ab_cap = '1; a_in = 16'h1111; step("R6");
    // R5: drive control high
    @(negedge clk); ab_drv = '1; step("R5");
    @(negedge clk); ab_drv = 2'b01; ab_en = 2'b10; step("R5");

    // R7: B-to-A path
    @(negedge clk); ab_en = '1; ab_drv = '1;
    ba_en = '0; ba_cap = '0; ba_drv = '0; b_in = 16'h8421; step("R7");
    @(negedge clk); ba_cap = '1; b_in = 16'h0000; step("R7");
    @(negedge clk); ba_drv = '1; step("R7");
    @(negedge clk); ba_drv = '0; ba_en = '1; step("R7");

    // R8: section independence
    @(negedge clk); ab_en = 2'b10; ab_cap = 2'b10; ab_drv = 2'b00; a_in = 16'hc35a; step("R8");
    @(negedge clk); ab_en = 2'b01; ab_cap = 2'b11; a_in = 16'h0000; step("R8");

    // R9: bus hold
    @(negedge clk); ab_en = '0; ab_cap = '0; ab_drv = '0; a_in = 16'h3c3c; step("R9");
    @(negedge clk); a_in = 16'hffff; a_val = 16'h00ff; step("R9");
    @(negedge clk); a_in = 16'h0000; a_val = 16'h0000; step("R9");
    @(negedge clk); a_val = 16'hf0f0; a_in = 16'ha5a5; step("R9");
    @(negedge clk); a_val = '1; b_val = 16'h0f00; ab_en = '1;
    ba_en = '0; ba_cap = '0; b_in = 16'hffff; step("R9");
    b_val = '1;

    // R10: power not good
    @(negedge clk); pwr = 1'b0; ab_en = '0; ab_cap = '0; ab_drv = '0;
    ba_en = '0; ba_cap = '0; ba_drv = '0; a_in = 16'h2468; b_in = 16'h1357; step("R10");
    @(negedge clk); ab_cap = '1; ba_cap = '1; step("R10");
    @(negedge clk); pwr = 1'b1; step("R10");

    // R11: contention
    @(negedge clk); ab_cap = '0; ba_cap = '0; step("R11");
    @(negedge clk); ba_cap = 2'b10; step("R11");
    @(negedge clk); ba_cap = 2'b00; ab_drv = 2'b01; step("R11");
    @(negedge clk); ab_en = '1; ba_en = '1; ab_cap = '1; ba_cap = '1; step("R11");

    @(negedge clk); @(negedge clk);
    finish_run();
  end
endmodule